// File: doc/BRIEF.md
# Matrix Keypad Scanner with Press Qualification

This block reads a 4x4 key matrix by pulling one row low at a time and looking at four column lines that are pulled up outside the chip. Rows are released rather than driven high, so a key that shorts two rows cannot cause contention. The block does not time itself. It moves to the next row only when an external scan-rate timer sends a one-cycle timeout pulse, so the period of that timer sets how long a press must last before it counts.

A press is accepted only after a clean start and a period of stable contact. First, one full pass over all rows must see the keypad idle. Then a single key, always the same one, must be the only key down for several full passes in a row. On acceptance the block latches a key code made of the row index and the column index, and raises a ready flag. The flag stays up until the consumer pulls the active-low read strobe low for one clock. A key that is still held after it has been reported is not reported again until the keypad has been seen idle for a whole pass.

Top module: `kps_keypad_scanner`

## Requirements
- R1: At most one row enable is high at any time. After reset the enabled row starts at row 0 and runs 0, 1, 2, 3, then back to 0. An enabled row pad drives 0 and every other row pad is high-impedance.
- R2: The enabled row moves to the next row only on a clock edge where `scan_tick` is high, and holds while `scan_tick` is low. The columns are sampled for the row that is enabled at that edge.
- R3: While `rst` is high, at the following clock edge all row enables are 0, `key_rdy` is 0 and `key_code` is 0. The block then waits for an idle scan.
- R4: A key held from reset onward is never accepted, because no scan with zero keys pressed has been seen yet.
- R5: After an idle scan, a single key that is the only key down for 4 consecutive full scans is accepted. `key_rdy` rises at the clock edge that takes the tick ending the 4th scan. `key_code` is {row index[1:0], column index[1:0]}, so row 2 column 1 gives 9.
- R6: A full scan with no key down resets the consecutive-scan count to zero.
- R7: A full scan with two or more keys down, in the same row or in different rows, resets the count to zero.
- R8: A single key that differs from the key being qualified restarts the count at 1 with the new key.
- R9: Once a key is accepted, nothing more is accepted until a full scan with no key down has been seen. A held key is reported only once.
- R10: `key_rdy` stays high until `read_n` is low at a clock edge, and it is low after that edge.
- R11: `key_code` does not change while `key_rdy` is high and no new key is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_tick | input | 1 | One-cycle timeout pulse from the scan-rate timer; samples the columns and moves to the next row |
| col_n | input | 4 | Column lines, pulled up, low when a key on the enabled row is down |
| read_n | input | 1 | Active-low read strobe that clears `key_rdy` |
| row_oe | output | 4 | Row enables, one-hot or zero; 1 means the row is pulled low |
| row_pad | output | 4 | Open-drain row pads: 0 when enabled, high-impedance otherwise |
| key_code | output | 4 | Accepted key, {row index, column index} |
| key_rdy | output | 1 | An accepted key is waiting to be read |

## Verification
Everything is decided at a `scan_tick` edge. A row change, and the `key_rdy` rise that ends the qualifying scan, appear one edge after the tick is sampled. The bench drives each tick for one cycle from a falling edge and reads the outputs on the next falling edge. A read strobe clears `key_rdy` at the single edge where `read_n` is low, so the bench checks the flag on the falling edge that follows. The scoreboard queues the expected code before the scan that should produce it. Its monitor compares each rising edge of `key_rdy` against the queue, and a rise with nothing queued is reported as a failure.

// File: rtl/kps_pkg.sv
package kps_pkg;

   // Saturating count of keys seen down within one scan
   typedef enum logic [1:0] {
      HITS_NONE = 2'd0,
      HITS_ONE  = 2'd1,
      HITS_MANY = 2'd2
   } hits_e;

   // Press qualifier state
   typedef enum logic [0:0] {
      ST_ARM  = 1'b0,   // waiting for a scan with no key down
      ST_QUAL = 1'b1    // counting consecutive single-key scans
   } qual_state_e;

   function automatic hits_e hits_add(input hits_e a, input hits_e b);
      hits_e r;
      if (a == HITS_NONE)      r = b;
      else if (b == HITS_NONE) r = a;
      else                     r = HITS_MANY;
      return r;
   endfunction

endpackage

// File: rtl/kps_row_seq.sv
module kps_row_seq #(
   parameter int NUM_ROWS = 4,
   localparam int RW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                scan_tick,
   output logic [RW-1:0]       row_idx,
   output logic [NUM_ROWS-1:0] row_oe,
   output logic                step,
   output logic                scan_last
);

   localparam logic [RW-1:0] LAST_ROW = RW'(NUM_ROWS - 1);

   logic running;

   always_ff @(posedge clk) begin
      if (rst) begin
         running <= 1'b0;
         row_idx <= '0;
      end else begin
         running <= 1'b1;
         if (step) begin
            row_idx <= (row_idx == LAST_ROW) ? '0 : row_idx + 1'b1;
         end
      end
   end

   assign step      = scan_tick & running;
   assign scan_last = step & (row_idx == LAST_ROW);

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_oe
      assign row_oe[r] = running & (row_idx == RW'(r));
   end

endmodule

// File: rtl/kps_col_acc.sv
module kps_col_acc
   import kps_pkg::*;
#(
   parameter int NUM_ROWS = 4,
   parameter int NUM_COLS = 4,
   localparam int RW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
   localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
   localparam int KW = RW + CW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step,
   input  logic                scan_last,
   input  logic [RW-1:0]       row_idx,
   input  logic [NUM_COLS-1:0] col_n,
   output logic                scan_done,
   output hits_e               scan_hits,
   output logic [KW-1:0]       scan_code
);

   hits_e         acc_hits;
   logic [KW-1:0] acc_code;
   hits_e         row_hits;
   logic [CW-1:0] row_col;

   // Count the low columns on the enabled row; keep the lowest index
   always_comb begin
      row_hits = HITS_NONE;
      row_col  = '0;
      for (int c = NUM_COLS - 1; c >= 0; c--) begin
         if (!col_n[c]) begin
            row_col  = CW'(c);
            row_hits = (row_hits == HITS_NONE) ? HITS_ONE : HITS_MANY;
         end
      end
   end

   // Scan totals including the row being sampled now
   always_comb begin
      scan_hits = hits_add(acc_hits, row_hits);
      scan_code = (acc_hits == HITS_NONE) ? {row_idx, row_col} : acc_code;
   end

   assign scan_done = scan_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_hits <= HITS_NONE;
         acc_code <= '0;
      end else if (step) begin
         if (scan_last) begin
            acc_hits <= HITS_NONE;
            acc_code <= '0;
         end else begin
            acc_hits <= scan_hits;
            acc_code <= scan_code;
         end
      end
   end

endmodule

// File: rtl/kps_qual_fsm.sv
module kps_qual_fsm
   import kps_pkg::*;
#(
   parameter int KW         = 4,
   parameter int QUAL_SCANS = 4,
   localparam int QW = $clog2(QUAL_SCANS + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          scan_done,
   input  hits_e         scan_hits,
   input  logic [KW-1:0] scan_code,
   input  logic          read_n,
   output logic [KW-1:0] key_code,
   output logic          key_rdy
);

   localparam logic [QW-1:0] QUAL_TARGET = QW'(QUAL_SCANS);

   qual_state_e   state;
   logic [QW-1:0] qcnt;
   logic [QW-1:0] qcnt_next;
   logic [KW-1:0] cand;

   // Count after a scan with exactly one key down
   always_comb begin
      if ((qcnt != '0) && (scan_code == cand)) qcnt_next = qcnt + 1'b1;
      else                                     qcnt_next = QW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_ARM;
         qcnt     <= '0;
         cand     <= '0;
         key_code <= '0;
         key_rdy  <= 1'b0;
      end else begin
         if (!read_n) key_rdy <= 1'b0;
         if (scan_done) begin
            unique case (state)
               ST_ARM: begin
                  if (scan_hits == HITS_NONE) begin
                     state <= ST_QUAL;
                     qcnt  <= '0;
                  end
               end
               ST_QUAL: begin
                  if (scan_hits == HITS_ONE) begin
                     cand <= scan_code;
                     if (qcnt_next == QUAL_TARGET) begin
                        key_code <= scan_code;
                        key_rdy  <= 1'b1;
                        state    <= ST_ARM;
                        qcnt     <= '0;
                     end else begin
                        qcnt <= qcnt_next;
                     end
                  end else begin
                     qcnt <= '0;
                  end
               end
               default: state <= ST_ARM;
            endcase
         end
      end
   end

endmodule

// File: rtl/kps_keypad_scanner.sv
module kps_keypad_scanner
   import kps_pkg::*;
#(
   parameter int NUM_ROWS   = 4,
   parameter int NUM_COLS   = 4,
   parameter int QUAL_SCANS = 4,
   parameter bit OPEN_DRAIN = 1'b1,
   localparam int RW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
   localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
   localparam int KW = RW + CW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                scan_tick,
   input  logic [NUM_COLS-1:0] col_n,
   input  logic                read_n,
   output logic [NUM_ROWS-1:0] row_oe,
   output wire  [NUM_ROWS-1:0] row_pad,
   output logic [KW-1:0]       key_code,
   output logic                key_rdy
);

   // Elaboration-time parameter checks
   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("kps_keypad_scanner: NUM_ROWS must be at least 2");
   end
   if (NUM_COLS < 2) begin : g_bad_cols
      $error("kps_keypad_scanner: NUM_COLS must be at least 2");
   end
   if (QUAL_SCANS < 1) begin : g_bad_qual
      $error("kps_keypad_scanner: QUAL_SCANS must be at least 1");
   end

   logic [RW-1:0] row_idx;
   logic          step;
   logic          scan_last;
   logic          scan_done;
   hits_e         scan_hits;
   logic [KW-1:0] scan_code;

   kps_row_seq #(.NUM_ROWS(NUM_ROWS)) u_rows (
      .clk       (clk),
      .rst       (rst),
      .scan_tick (scan_tick),
      .row_idx   (row_idx),
      .row_oe    (row_oe),
      .step      (step),
      .scan_last (scan_last)
   );

   kps_col_acc #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_cols (
      .clk       (clk),
      .rst       (rst),
      .step      (step),
      .scan_last (scan_last),
      .row_idx   (row_idx),
      .col_n     (col_n),
      .scan_done (scan_done),
      .scan_hits (scan_hits),
      .scan_code (scan_code)
   );

   kps_qual_fsm #(.KW(KW), .QUAL_SCANS(QUAL_SCANS)) u_qual (
      .clk       (clk),
      .rst       (rst),
      .scan_done (scan_done),
      .scan_hits (scan_hits),
      .scan_code (scan_code),
      .read_n    (read_n),
      .key_code  (key_code),
      .key_rdy   (key_rdy)
   );

   // Pad variant: open-drain release or push-pull high for idle rows
   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_pad
      if (OPEN_DRAIN) begin : g_od
         assign row_pad[r] = row_oe[r] ? 1'b0 : 1'bz;
      end else begin : g_pp
         assign row_pad[r] = ~row_oe[r];
      end
   end

endmodule

// File: rtl/kps_keypad_scanner_chk.sv
module kps_keypad_scanner_chk #(
   parameter int NUM_ROWS = 4,
   parameter int KW       = 4
) (
   input logic                clk,
   input logic                rst,
   input logic                scan_tick,
   input logic                read_n,
   input logic [NUM_ROWS-1:0] row_oe,
   input logic [KW-1:0]       key_code,
   input logic                key_rdy
);

   assert_row_onehot_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_oe));

   assert_row_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!scan_tick && row_oe != '0) |=> $stable(row_oe));

   assert_row_step_R2: assert property (@(posedge clk) disable iff (rst)
      (scan_tick && row_oe != '0) |=> (row_oe != $past(row_oe)));

   assert_reset_state_R3: assert property (@(posedge clk)
      rst |=> (row_oe == '0 && !key_rdy && key_code == '0));

   assert_accept_at_scan_end_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(key_rdy) |-> $past(scan_tick && row_oe[NUM_ROWS-1]));

   assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
      (!read_n && !scan_tick) |=> !key_rdy);

   assert_code_held_R11: assert property (@(posedge clk) disable iff (rst)
      (key_rdy && !scan_tick) |=> $stable(key_code));

endmodule

bind kps_keypad_scanner kps_keypad_scanner_chk #(
   .NUM_ROWS (NUM_ROWS),
   .KW       (KW)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .scan_tick (scan_tick),
   .read_n    (read_n),
   .row_oe    (row_oe),
   .key_code  (key_code),
   .key_rdy   (key_rdy)
);

// File: tb/kps_keypad_scanner_tb_top.sv
`timescale 1ns/1ps
module kps_keypad_scanner_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       scan_tick = 1'b0;
   logic       read_n = 1'b1;
   logic [3:0] col_n;
   logic [3:0] row_oe;
   wire  [3:0] row_pad;
   logic [3:0] key_code;
   logic       key_rdy;

   logic [15:0] keys = '0;   // keys[row*4+col] = 1 means down
   int vectors = 0;
   int fails   = 0;
   int exp_q[$];
   logic rdy_q = 1'b0;
   bit   done  = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   kps_keypad_scanner dut_i (
      .clk       (clk),
      .rst       (rst),
      .scan_tick (scan_tick),
      .col_n     (col_n),
      .read_n    (read_n),
      .row_oe    (row_oe),
      .row_pad   (row_pad),
      .key_code  (key_code),
      .key_rdy   (key_rdy)
   );

   // Keypad model: a down key pulls its column low when its row is enabled
   always_comb begin
      for (int c = 0; c < 4; c++) begin
         col_n[c] = 1'b1;
         for (int r = 0; r < 4; r++) begin
            if (row_oe[r] && keys[r*4+c]) col_n[c] = 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) scan_tick = 1'b1;
      @(negedge clk) scan_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic scans(input int n);
      repeat (n * 4) tick();
   endtask

   task automatic press(input int r, input int c);
      keys = '0;
      keys[r*4+c] = 1'b1;
   endtask

   task automatic expect_key(input int code);
      exp_q.push_back(code);
   endtask

   task automatic do_read();
      @(negedge clk) read_n = 1'b0;
      @(negedge clk) read_n = 1'b1;
      check(key_rdy == 1'b0, "R10 read clears ready", key_rdy, 0);
   endtask

   // Monitor: each rise of key_rdy must match the head of the queue
   always @(negedge clk) begin
      if (!rst) begin
         if (key_rdy && !rdy_q) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected report", key_code, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(key_code == 4'(e), "R5 scoreboard code", key_code, e);
            end
         end
         rdy_q = key_rdy;
      end
   end

   initial begin
      // R3 and R4: reset with a key already held
      press(1, 1);
      repeat (3) @(negedge clk);
      check(row_oe == 4'b0000, "R3 rows released in reset", row_oe, 0);
      check(key_rdy == 1'b0, "R3 ready low in reset", key_rdy, 0);
      check(key_code == 4'd0, "R3 code zero in reset", key_code, 0);
      rst = 1'b0;
      @(negedge clk); @(negedge clk);
      check(row_oe == 4'b0001, "R1 first row after reset", row_oe, 1);
      // R1/R2: row order over one scan
      for (int i = 1; i <= 4; i++) begin
         tick();
         check(row_oe == 4'(1 << (i % 4)), "R1 row order", row_oe, 1 << (i % 4));
      end
      scans(5);
      check(key_rdy == 1'b0, "R4 held-from-reset key rejected", key_rdy, 0);

      // R5: idle scan, then four scans of row 2 column 1
      keys = '0;
      scans(1);
      press(2, 1);
      scans(3);
      check(key_rdy == 1'b0, "R5 not ready after 3 scans", key_rdy, 0);
      expect_key(9);
      scans(1);
      check(key_rdy == 1'b1, "R5 ready after 4th scan", key_rdy, 1);
      check(key_code == 4'd9, "R5 code row2 col1", key_code, 9);

      // R2: no tick, row holds
      repeat (10) @(negedge clk);
      check(row_oe == 4'b0001, "R2 row holds without tick", row_oe, 1);
      check(key_rdy == 1'b1, "R10 ready holds without read", key_rdy, 1);

      // R9/R11: held key gives no second report and the code holds
      scans(5);
      check(key_code == 4'd9, "R11 code held", key_code, 9);
      do_read();
      scans(4);
      check(key_rdy == 1'b0, "R9 held key not reported again", key_rdy, 0);

      // R6: an idle scan in the middle restarts the count
      keys = '0;
      scans(1);
      press(0, 3);
      scans(3);
      keys = '0;
      scans(1);
      press(0, 3);
      scans(3);
      check(key_rdy == 1'b0, "R6 idle scan restarts count", key_rdy, 0);
      expect_key(3);
      scans(1);
      check(key_rdy == 1'b1 && key_code == 4'd3, "R6 accepted after restart", key_code, 3);
      do_read();

      // R7: a scan with two keys down restarts the count
      keys = '0;
      scans(1);
      press(1, 2);
      scans(3);
      keys[3*4+0] = 1'b1;
      scans(1);
      press(1, 2);
      scans(3);
      check(key_rdy == 1'b0, "R7 multi-key scan restarts count", key_rdy, 0);
      expect_key(6);
      scans(1);
      check(key_rdy == 1'b1 && key_code == 4'd6, "R7 accepted after restart", key_code, 6);
      do_read();

      // R8: a different key restarts the count at 1
      keys = '0;
      scans(1);
      press(3, 3);
      scans(2);
      press(2, 0);
      scans(3);
      check(key_rdy == 1'b0, "R8 new key counted from 1", key_rdy, 0);
      expect_key(8);
      scans(1);
      check(key_rdy == 1'b1 && key_code == 4'd8, "R8 new key accepted", key_code, 8);
      do_read();

      check(exp_q.size() == 0, "R5 all expected keys reported", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule